// File: doc/BRIEF.md
# Particle Regularization Jitter Datapath

This block perturbs one resampled particle state per transaction. Each transaction carries three values: the particle's current state, a square-root covariance factor, and a noise sample drawn from a zero-mean, unit-variance normal source. The block multiplies the factor by the noise sample. It then scales that product by a fixed bandwidth constant and adds the scaled value to the state. The result is a wide regularized state. The noise source and the covariance factor are produced elsewhere and arrive at the input.

Both the input and the output use valid/ready streams. A transfer happens on any rising clock edge where both valid and ready are high. Once the producer raises `in_valid`, it must hold `in_valid` and the data stable until the transfer. The block holds `out_valid` and `out_state` until the consumer takes the result. When the result is stalled, the whole pipeline freezes and `in_ready` drops, so back-pressure reaches the producer in the same cycle.

The parameter `LANES` sets how many multipliers are built. With two lanes, one multiplier forms the factor×noise product and a second applies the constant, so a new particle can enter every cycle. With one lane, a single wide multiplier does both products in turn, so a new particle can enter at most every second cycle. The latency and the numeric result are the same in both variants.

Top module: `rgl_perturb`

## Requirements
- R1: For each accepted input, `out_state` equals `in_state + K × (in_sqrt × in_noise)` modulo 2^106, where K is the 53-bit signed parameter `BW_K`.
- R2: `in_sqrt`, `in_noise` and `BW_K` are two's-complement signed values. Both products are sign-extended with no bits dropped, so a negative factor or noise sample gives the exact signed result. This includes both inputs at -2^23.
- R3: If a particle is accepted in cycle c and the output is not back-pressured, `out_valid` is high with that particle's result in cycle c+3.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_state` holds its value in the next cycle.
- R5: While `out_valid` is high and `out_ready` is low, `in_ready` is low.
- R6: With `LANES`=2, `in_ready` is high whenever `out_ready` is high. With `LANES`=1, `in_ready` is low in the cycle after any accepted input.
- R7: Results leave in the order particles entered, and both lane variants give identical results for the same input sequence.
- R8: After reset is released, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input particle present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_state | input | 106 | Particle state before jitter |
| in_sqrt | input | 24 | Signed square-root covariance factor |
| in_noise | input | 24 | Signed normal noise sample |
| out_valid | output | 1 | Regularized state present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_state | output | 106 | Regularized particle state |

## Verification
The hardest case to reach is the single-lane variant with a stage-2 particle that holds the shared multiplier while the output is also stalled and the producer is still offering data. In that situation, the ready rule and the multiplier selection interact. The bench reaches it by driving both variants side by side from one item list, with random gaps on the producer side and frequent random back-pressure on the consumer side. It then compares each result against a bench-computed value, and compares the two variants' result sets with each other. Directed items cover the extreme signed operands and the lone-particle latency.

// File: rtl/rgl_pkg.sv
package rgl_pkg;
  localparam int unsigned DEF_SQ_W = 24;
  localparam int unsigned DEF_NZ_W = 24;
  localparam int unsigned DEF_K_W  = 53;
  localparam int unsigned DEF_ST_W = 106;
  // default bandwidth scale, 53-bit signed (positive)
  localparam logic [52:0] DEF_BW_K = 53'h06A3F19C2D85B;
endpackage

// File: rtl/rgl_mul.sv
module rgl_mul #(
  parameter int unsigned AW = 24,
  parameter int unsigned BW = 24
) (
  input  logic signed [AW-1:0]    a,
  input  logic signed [BW-1:0]    b,
  output logic signed [AW+BW-1:0] p
);
  always_comb p = a * b;
endmodule

// File: rtl/rgl_ctrl.sv
module rgl_ctrl #(
  parameter int unsigned LANES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic adv,
  output logic take,
  output logic v1,
  output logic v2,
  output logic out_valid
);
  always_comb adv = !out_valid || out_ready;

  generate
    if (LANES == 1) begin : g_one
      // stage 2 owns the shared multiplier whenever v1 is set
      always_comb in_ready = adv && !v1;
    end else begin : g_two
      always_comb in_ready = adv;
    end
  endgenerate

  always_comb take = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
    end else if (adv) begin
      v1        <= take;
      v2        <= v1;
      out_valid <= v2;
    end
  end

  // R5: a stalled result blocks new input
  a_r5_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R4: a stalled result is not withdrawn
  a_r4_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R3: a particle in stage 2 reaches the output on the next advance
  a_r3_stage_to_out: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && adv) |=> out_valid);

  generate
    if (LANES == 1) begin : g_chk_one
      // R6: single-lane accepts at most every second cycle
      a_r6_one_lane_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
    end else begin : g_chk_two
      // R6: dual-lane never throttles an unstalled stream
      a_r6_two_lane_rate: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);
    end
  endgenerate
endmodule

// File: rtl/rgl_perturb.sv
module rgl_perturb import rgl_pkg::*; #(
  parameter int unsigned SQ_W  = DEF_SQ_W,
  parameter int unsigned NZ_W  = DEF_NZ_W,
  parameter int unsigned K_W   = DEF_K_W,
  parameter int unsigned ST_W  = DEF_ST_W,
  parameter int unsigned LANES = 2,
  parameter logic [K_W-1:0] BW_K = K_W'(DEF_BW_K)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [ST_W-1:0] in_state,
  input  logic [SQ_W-1:0] in_sqrt,
  input  logic [NZ_W-1:0] in_noise,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [ST_W-1:0] out_state
);
  localparam int unsigned PW = SQ_W + NZ_W;  // factor x noise
  localparam int unsigned QW = K_W + PW;     // scaled perturbation
  localparam int unsigned XW = ST_W - QW;    // sign-extension bits

  logic adv, take, v1, v2;

  rgl_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .adv(adv), .take(take), .v1(v1), .v2(v2),
    .out_valid(out_valid)
  );

  logic signed [PW-1:0] p1_q, p1_d;
  logic signed [QW-1:0] p2_q, p2_d;
  logic [ST_W-1:0]      st1_q, st2_q;

  generate
    if (LANES == 1) begin : g_shared
      logic signed [K_W-1:0] op_a;
      logic signed [PW-1:0]  op_b;
      logic signed [QW-1:0]  m;
      always_comb begin
        if (v1) begin
          op_a = $signed(BW_K);
          op_b = p1_q;
        end else begin
          op_a = {{(K_W-SQ_W){in_sqrt[SQ_W-1]}}, in_sqrt};
          op_b = {{(PW-NZ_W){in_noise[NZ_W-1]}}, in_noise};
        end
      end
      rgl_mul #(.AW(K_W), .BW(PW)) u_mul (.a(op_a), .b(op_b), .p(m));
      always_comb begin
        p1_d = m[PW-1:0];
        p2_d = m;
      end
    end else begin : g_dual
      rgl_mul #(.AW(SQ_W), .BW(NZ_W)) u_mul_fn (
        .a($signed(in_sqrt)), .b($signed(in_noise)), .p(p1_d));
      rgl_mul #(.AW(K_W), .BW(PW)) u_mul_k (
        .a($signed(BW_K)), .b(p1_q), .p(p2_d));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p1_q      <= '0;
      p2_q      <= '0;
      st1_q     <= '0;
      st2_q     <= '0;
      out_state <= '0;
    end else if (adv) begin
      if (take) begin
        p1_q  <= p1_d;
        st1_q <= in_state;
      end
      if (v1) begin
        p2_q  <= p2_d;
        st2_q <= st1_q;
      end
      if (v2) out_state <= st2_q + {{XW{p2_q[QW-1]}}, p2_q};
    end
  end

  // R4: result data is frozen while the consumer stalls
  a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_state));

  // R7: an advancing empty output stage never shows data
  a_r7_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !v2) |=> !out_valid);
endmodule

// File: tb/sim_rgl_perturb.sv
module sim_rgl_perturb;
  import rgl_pkg::*;
  localparam int NITEM = 300;
  localparam logic signed [52:0] KB = DEF_BW_K;

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst_n;

  logic iv [2];
  logic ir [2];
  logic ov [2];
  logic ordy [2];
  logic [105:0] ist [2];
  logic [105:0] ost [2];
  logic [23:0] isq [2];
  logic [23:0] inz [2];

  rgl_perturb #(.LANES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[0]), .in_ready(ir[0]),
    .in_state(ist[0]), .in_sqrt(isq[0]), .in_noise(inz[0]),
    .out_valid(ov[0]), .out_ready(ordy[0]), .out_state(ost[0]));
  rgl_perturb #(.LANES(1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[1]), .in_ready(ir[1]),
    .in_state(ist[1]), .in_sqrt(isq[1]), .in_noise(inz[1]),
    .out_valid(ov[1]), .out_ready(ordy[1]), .out_state(ost[1]));

  logic [105:0] st_a [NITEM];
  logic [23:0]  sq_a [NITEM];
  logic [23:0]  nz_a [NITEM];
  logic [105:0] res [2][NITEM];
  int q0[$];
  int q1[$];
  int ptr [2];
  int lim [2];
  logic will_acc [2];
  logic prev_stall [2];
  logic prev_acc [2];
  logic [105:0] prev_out [2];
  int acc_cyc [2];
  int out_cyc [2];
  int cyc = 0;
  int vec = 0;
  int bad = 0;

  function automatic logic [105:0] expv(int i);
    logic signed [47:0]  p;
    logic signed [105:0] q;
    p = $signed(sq_a[i]) * $signed(nz_a[i]);
    q = KB * p;
    return st_a[i] + q;
  endfunction

  task automatic check(bit ok, string req, logic [105:0] act, logic [105:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic drive(int rpct, int vpct);
    for (int d = 0; d < 2; d++) begin
      ordy[d] = ($urandom_range(99) < rpct);
      if (will_acc[d]) iv[d] = 1'b0;
      if (!iv[d] && ptr[d] < lim[d] && $urandom_range(99) < vpct) begin
        iv[d]  = 1'b1;
        ist[d] = st_a[ptr[d]];
        isq[d] = sq_a[ptr[d]];
        inz[d] = nz_a[ptr[d]];
      end
    end
  endtask

  task automatic sample();
    int idx;
    for (int d = 0; d < 2; d++) begin
      if (prev_stall[d]) begin
        check(ov[d], "R4 valid", {105'd0, ov[d]}, 106'd1);
        check(ost[d] == prev_out[d], "R4 data", ost[d], prev_out[d]);
      end
      if (ov[d] && !ordy[d]) check(!ir[d], "R5", {105'd0, ir[d]}, 106'd0);
      if (d == 1 && prev_acc[1]) check(!ir[1], "R6 one-lane", {105'd0, ir[1]}, 106'd0);
      if (d == 0 && ordy[0]) check(ir[0], "R6 two-lane", {105'd0, ir[0]}, 106'd1);
      will_acc[d] = iv[d] && ir[d];
      if (will_acc[d]) begin
        if (d == 0) q0.push_back(ptr[d]); else q1.push_back(ptr[d]);
        if (ptr[d] == 0) acc_cyc[d] = cyc;
        ptr[d]++;
      end
      if (ov[d] && ordy[d]) begin
        if (d == 0) idx = q0.pop_front(); else idx = q1.pop_front();
        if (idx < 5) check(ost[d] == expv(idx), "R2 signed corner", ost[d], expv(idx));
        else         check(ost[d] == expv(idx), "R1 result", ost[d], expv(idx));
        res[d][idx] = ost[d];
        if (idx == 0) out_cyc[d] = cyc;
      end
      prev_stall[d] = ov[d] && !ordy[d];
      prev_out[d]   = ost[d];
      prev_acc[d]   = will_acc[d];
    end
    cyc++;
  endtask

  task automatic step(int rpct, int vpct);
    @(negedge clk);
    drive(rpct, vpct);
    #5;
    sample();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vec++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [127:0] w;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NITEM; i++) begin
      w = {$urandom(), $urandom(), $urandom(), $urandom()};
      st_a[i] = w[105:0];
      sq_a[i] = 24'($urandom());
      nz_a[i] = 24'($urandom());
    end
    // directed signed corners (R2)
    sq_a[0] = 24'h800000; nz_a[0] = 24'h800000; st_a[0] = '0;
    sq_a[1] = 24'h7FFFFF; nz_a[1] = 24'h800000;
    sq_a[2] = 24'h123456; nz_a[2] = 24'h000000;
    sq_a[3] = 24'hFFFFFF; nz_a[3] = 24'h000001; st_a[3] = '0;
    sq_a[4] = 24'h7FFFFF; nz_a[4] = 24'h7FFFFF; st_a[4] = {1'b0, {105{1'b1}}};
    for (int d = 0; d < 2; d++) begin
      iv[d] = 1'b0; ordy[d] = 1'b0; ist[d] = '0; isq[d] = '0; inz[d] = '0;
      ptr[d] = 0; lim[d] = 1; will_acc[d] = 1'b0;
      prev_stall[d] = 1'b0; prev_acc[d] = 1'b0; prev_out[d] = '0;
      acc_cyc[d] = -1; out_cyc[d] = -1;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    for (int d = 0; d < 2; d++) begin
      check(!ov[d], "R8 out_valid", {105'd0, ov[d]}, 106'd0);
      check(ir[d], "R8 in_ready", {105'd0, ir[d]}, 106'd1);
    end
    // lone particle latency (R3)
    for (int k = 0; k < 8; k++) step(100, 100);
    for (int d = 0; d < 2; d++)
      check(out_cyc[d] - acc_cyc[d] == 3, "R3 latency",
            106'(out_cyc[d] - acc_cyc[d]), 106'd3);
    // random streaming with back-pressure
    lim[0] = NITEM; lim[1] = NITEM;
    for (int k = 0; k < 1500; k++) step(65, 80);
    while (ptr[0] < NITEM || ptr[1] < NITEM || q0.size() != 0 || q1.size() != 0)
      step(100, 100);
    // variants agree, order preserved (R7)
    for (int i = 0; i < NITEM; i++)
      check(res[0][i] == res[1][i], "R7 lanes agree", res[1][i], res[0][i]);
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule